// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block turns the peripheral clock into the sixteen-times-oversampling enable pulse that a UART serializer and deserializer advance on. It divides the clock by a 16-bit integer divisor and then applies a fractional prescale of (1 + A/M), where A is the add value and M is the multiplier value. The long-term pulse rate is therefore clk / (divisor × (1 + A/M)), and the serial bit rate is one sixteenth of that.

Non-integer ratios are met on average, not cycle by cycle. A small accumulator modulo M gains A at every pulse. Each time it wraps, the following pulse period is stretched by one whole divisor. Software programs the divisor as two byte registers and the fractional values as one packed byte. All three writes pass only while the access-latch bit is set. The block also enforces the hardware minimums on the divisor, and it switches to a new setting only at a pulse boundary.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst` is high, `tick_o` is low and every register clears. After reset the divisor reads as zero and the fractional setting as empty, so `tick_o` is high in every cycle.
- R2: With an add value of 0, consecutive `tick_o` pulses are exactly D clock cycles apart, where D is the effective divisor.
- R3: Writes use `wr_addr` as follows:
  - 0 is the divisor low byte (bits 7:0).
  - 1 is the divisor high byte (bits 15:8).
  - 2 is the fractional byte, with the add value in bits 3:0 and the multiplier in bits 7:4.
  - 3 is the control byte, whose bit 7 is the access latch.
- R4: While the access latch is clear, writes to addresses 0, 1 and 2 are ignored.
- R5: A divisor of zero (both bytes zero) behaves as a divisor of 1.
- R6: When the add value in effect is non-zero, a divisor below 2 behaves as 2.
- R7: On each pulse the add value is added to an accumulator that is kept modulo the multiplier. When the sum reaches the multiplier, the next period lasts 2·D cycles; otherwise it lasts D cycles.
- R8: A multiplier of 0, or an add value not below the multiplier, makes the block behave as if the add value were 0.
- R9: A new setting takes effect only at the next pulse, so the period already running ends at its original length.
- R10: When the setting in effect changes at a pulse, the accumulator restarts at zero. The first period under the new setting is an unstretched D.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (see R3) |
| wr_data | input | 8 | Write data byte |
| tick_o | output | 1 | Oversampling enable pulse |

## Verification
The bench uses the default parameters: two divisor bytes and 4-bit fractional fields. This covers a divisor that needs the high byte (259) alongside the degenerate settings 0 and 1, which the minimum rules rewrite. Multipliers of 2 and 3 keep the stretch cycle short. A few pulses are then enough to see the full pattern of plain and doubled periods, and to tell an accumulator restart from a carried-over phase.

// File: rtl/fbg_pkg.sv
`timescale 1ns/1ps
package fbg_pkg;

    // sizing
    parameter int unsigned DIV_BYTES = 2;   // byte registers forming the divisor
    parameter int unsigned FRAC_W    = 4;   // width of add value and multiplier

    localparam int unsigned DIV_W     = 8 * DIV_BYTES;
    localparam int unsigned CNT_W     = DIV_W + 1;        // room for a doubled period
    localparam int unsigned ACC_W     = FRAC_W + 1;       // sum of two fields
    localparam int unsigned N_REGS    = DIV_BYTES + 2;
    localparam int unsigned ADDR_W    = $clog2(N_REGS);
    localparam int unsigned FRAC_ADDR = DIV_BYTES;
    localparam int unsigned CTRL_ADDR = DIV_BYTES + 1;
    localparam int unsigned LATCH_BIT = 7;

    // rate setting as used by the period logic
    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [FRAC_W-1:0] dadd;
        logic [FRAC_W-1:0] mul;
    } rate_cfg_t;

    // what happens at a pulse boundary
    typedef enum logic [1:0] {
        STEP_IDLE    = 2'd0,
        STEP_PLAIN   = 2'd1,
        STEP_STRETCH = 2'd2,
        STEP_RESTART = 2'd3
    } step_e;

    // apply legality rules and hardware minimums to raw register contents
    function automatic rate_cfg_t fbg_normalize(
        input logic [DIV_W-1:0]    div_raw,
        input logic [2*FRAC_W-1:0] frac_raw
    );
        rate_cfg_t c;
        c.dadd = frac_raw[FRAC_W-1:0];
        c.mul  = frac_raw[2*FRAC_W-1:FRAC_W];
        if (c.mul == '0 || c.dadd >= c.mul) begin
            c.dadd = '0;
            c.mul  = FRAC_W'(1);
        end
        c.div = div_raw;
        if (c.div == '0)
            c.div = DIV_W'(1);
        if (c.dadd != '0 && c.div < DIV_W'(2))
            c.div = DIV_W'(2);
        return c;
    endfunction

    function automatic rate_cfg_t fbg_reset_cfg();
        return fbg_normalize('0, '0);
    endfunction

endpackage

// File: rtl/fbg_regs.sv
`timescale 1ns/1ps
module fbg_regs
    import fbg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [7:0]           wr_data,
    output logic [DIV_W-1:0]     div_raw,
    output logic [2*FRAC_W-1:0]  frac_raw,
    output logic                 latch_o
);

    logic latch_q;
    logic gate_open;

    assign gate_open = wr_en && latch_q;

    // one byte register per divisor slice
    for (genvar g = 0; g < DIV_BYTES; g++) begin : g_div_byte
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst)
                byte_q <= '0;
            else if (gate_open && wr_addr == ADDR_W'(g))
                byte_q <= wr_data;
        end
        assign div_raw[8*g +: 8] = byte_q;
    end

    logic [2*FRAC_W-1:0] frac_q;
    always_ff @(posedge clk) begin
        if (rst)
            frac_q <= '0;
        else if (gate_open && wr_addr == ADDR_W'(FRAC_ADDR))
            frac_q <= wr_data[2*FRAC_W-1:0];
    end

    // the control byte is always writable; only the latch bit is kept
    always_ff @(posedge clk) begin
        if (rst)
            latch_q <= 1'b0;
        else if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR))
            latch_q <= wr_data[LATCH_BIT];
    end

    assign frac_raw = frac_q;
    assign latch_o  = latch_q;

endmodule

// File: rtl/fbg_frac.sv
`timescale 1ns/1ps
module fbg_frac
    import fbg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [DIV_W-1:0]     div_raw,
    input  logic [2*FRAC_W-1:0]  frac_raw,
    output rate_cfg_t            act_o,
    output logic [FRAC_W-1:0]    acc_o,
    output step_e                step_o,
    output logic [DIV_W-1:0]     next_div_o
);

    rate_cfg_t          pend;
    rate_cfg_t          act_q;
    logic [FRAC_W-1:0]  acc_q;
    logic [FRAC_W-1:0]  acc_nxt;
    logic [ACC_W-1:0]   sum;
    logic [ACC_W-1:0]   mul_ext;
    step_e              step;

    assign pend    = fbg_normalize(div_raw, frac_raw);
    assign sum     = ACC_W'(acc_q) + ACC_W'(pend.dadd);
    assign mul_ext = ACC_W'(pend.mul);

    always_comb begin
        step    = STEP_IDLE;
        acc_nxt = acc_q;
        if (tick) begin
            if (pend != act_q) begin
                step    = STEP_RESTART;
                acc_nxt = '0;
            end else if (sum >= mul_ext) begin
                step    = STEP_STRETCH;
                acc_nxt = FRAC_W'(sum - mul_ext);
            end else begin
                step    = STEP_PLAIN;
                acc_nxt = FRAC_W'(sum);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= fbg_reset_cfg();
            acc_q <= '0;
        end else if (tick) begin
            act_q <= pend;
            acc_q <= acc_nxt;
        end
    end

    assign act_o      = act_q;
    assign acc_o      = acc_q;
    assign step_o     = step;
    assign next_div_o = pend.div;

endmodule

// File: rtl/fbg_period.sv
`timescale 1ns/1ps
module fbg_period
    import fbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  step_e             step,
    input  logic [DIV_W-1:0]  next_div,
    output logic              tick_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;

    assign reload = (step == STEP_STRETCH) ? {next_div, 1'b0} : {1'b0, next_div};
    assign tick_o = !rst && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick_o)
            cnt_q <= reload - CNT_W'(1);
        else
            cnt_q <= cnt_q - CNT_W'(1);
    end

endmodule

// File: rtl/frac_baud_gen.sv
`timescale 1ns/1ps
module frac_baud_gen
    import fbg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [7:0]         wr_data,
    output logic               tick_o
);

    logic [DIV_W-1:0]    div_raw;
    logic [2*FRAC_W-1:0] frac_raw;
    logic                latch;
    rate_cfg_t           act_cfg;
    logic [FRAC_W-1:0]   acc_q;
    step_e               step;
    logic [DIV_W-1:0]    next_div;

    fbg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .div_raw  (div_raw),
        .frac_raw (frac_raw),
        .latch_o  (latch)
    );

    fbg_frac u_frac (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_o),
        .div_raw    (div_raw),
        .frac_raw   (frac_raw),
        .act_o      (act_cfg),
        .acc_o      (acc_q),
        .step_o     (step),
        .next_div_o (next_div)
    );

    fbg_period u_period (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .next_div (next_div),
        .tick_o   (tick_o)
    );

endmodule

// File: rtl/fbg_checker.sv
`timescale 1ns/1ps
module fbg_checker
    import fbg_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic                 latch,
    input logic [DIV_W-1:0]     div_raw,
    input logic [2*FRAC_W-1:0]  frac_raw,
    input rate_cfg_t            act,
    input logic [FRAC_W-1:0]    acc,
    input logic                 tick
);

    // R5: the divisor in use is never zero
    a_r5_div_nonzero: assert property (@(posedge clk) disable iff (rst)
        act.div != '0);

    // R6: a fractional setting in use never runs on a divisor below 2
    a_r6_frac_min: assert property (@(posedge clk) disable iff (rst)
        (act.dadd != '0) |-> (act.div >= DIV_W'(2)));

    // R8: the add value in use is always below the multiplier
    a_r8_frac_legal: assert property (@(posedge clk) disable iff (rst)
        act.dadd < act.mul);

    // R7: the accumulator stays inside its modulus
    a_r7_acc_bound: assert property (@(posedge clk) disable iff (rst)
        acc < act.mul);

    // R9: the setting in use changes only at a pulse boundary
    a_r9_cfg_at_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(act));

    // R4: divisor and fractional bytes hold while the latch is clear
    a_r4_latch_gate: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !latch && wr_addr != ADDR_W'(CTRL_ADDR))
            |=> ($stable(div_raw) && $stable(frac_raw)));

endmodule

bind frac_baud_gen fbg_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .latch    (latch),
    .div_raw  (div_raw),
    .frac_raw (frac_raw),
    .act      (act_cfg),
    .acc      (acc_q),
    .tick     (tick_o)
);

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;
    import fbg_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              tick_o;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    last = 0;
    bit    armed = 0;
    bit    sync_req = 0;
    int    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    frac_baud_gen u_frac_baud_gen (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tick_o  (tick_o)
    );

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: measure pulse spacing and compare against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && tick_o) begin
                if (sync_req) begin
                    sync_req = 0;
                    armed    = 1;
                    last     = cyc;
                end else if (armed) begin
                    if (exp_q.size() == 0) begin
                        armed = 0;
                    end else begin
                        check(cyc - last, exp_q.pop_front(), tag_q.pop_front());
                        last = cyc;
                    end
                end
            end
        end
    end

    task automatic wr(input int a, input int v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(a);
        wr_data = 8'(v);
        @(posedge clk);
        #1;
        wr_en   = 1'b0;
    endtask

    // R3: addresses 0/1 divisor bytes, 2 fractional, 3 control (bit 7 latch)
    task automatic set_cfg(input int div, input int frac);
        wr(3, 8'h80);
        wr(0, div & 255);
        wr(1, (div >> 8) & 255);
        wr(2, frac);
    endtask

    // expected spacing, derived from the requirements
    task automatic push_pattern(input int div, input int frac, input int n, input string tag);
        int d = frac & 15;
        int m = (frac >> 4) & 15;
        int acc = 0;
        if (m == 0 || d >= m) begin d = 0; m = 1; end      // R8
        if (div == 0) div = 1;                             // R5
        if (d != 0 && div < 2) div = 2;                    // R6
        exp_q.push_back(div); tag_q.push_back(tag);        // R10 first period
        for (int k = 1; k < n; k++) begin
            int s = acc + d;
            if (s >= m) begin
                acc = s - m;
                exp_q.push_back(2 * div);                  // R7 stretch
            end else begin
                acc = s;
                exp_q.push_back(div);
            end
            tag_q.push_back(tag);
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        #1;
    endtask

    task automatic wait_armed();
        while (!armed) @(posedge clk);
        #1;
    endtask

    task automatic run_cfg(input int div, input int frac, input int n, input string tag);
        set_cfg(div, frac);
        armed = 0;
        push_pattern(div, frac, n, tag);
        sync_req = 1;
        drain();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: quiet during reset, then a pulse every cycle
        repeat (3) @(negedge clk);
        check(int'(tick_o), 0, "R1 tick during reset");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(int'(tick_o), 1, "R1 tick after reset");
        armed = 0;
        push_pattern(0, 0, 4, "R1 zero divisor after reset");
        sync_req = 1;
        drain();

        run_cfg(10, 8'h10, 5, "R2 integer divisor");
        run_cfg(259, 8'h10, 3, "R3 high byte divisor");
        run_cfg(4, 8'h21, 8, "R7 add 1 mul 2");
        run_cfg(1, 8'h31, 8, "R6 divisor 1 raised to 2");
        run_cfg(0, 8'h10, 4, "R5 zero divisor");
        run_cfg(0, 8'h21, 6, "R6 zero divisor with fraction");
        run_cfg(6, 8'h35, 4, "R8 add not below mul");
        run_cfg(5, 8'h07, 4, "R8 mul zero");

        // R4: with the latch clear, byte writes have no effect on spacing
        set_cfg(12, 8'h10);
        wr(3, 8'h00);
        armed = 0;
        push_pattern(12, 8'h10, 6, "R4 write ignored without latch");
        sync_req = 1;
        wait_armed();
        repeat (3) @(posedge clk);
        wr(0, 3);
        wr(1, 1);
        wr(2, 8'h21);
        drain();

        // R9: a change mid-period leaves the running period intact
        set_cfg(40, 8'h10);
        armed = 0;
        exp_q.push_back(40); tag_q.push_back("R9 running period kept");
        for (int k = 0; k < 4; k++) begin
            exp_q.push_back(7); tag_q.push_back("R9 new divisor");
        end
        sync_req = 1;
        wait_armed();
        repeat (5) @(posedge clk);
        wr(0, 7);
        drain();

        // R10: accumulator phase is non-zero when the setting changes
        run_cfg(6, 8'h31, 8, "R7 add 1 mul 3");
        wr(2, 8'h32);
        armed = 0;
        push_pattern(6, 8'h32, 7, "R10 restart after change");
        sync_req = 1;
        drain();

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule